// File: doc/BRIEF.md
# Two-Wire Sensor Command Transmitter

This block is the transmit side of a bit-level master for a two-wire sensor link. The link has a clock that the master always drives and a single data wire shared by master and sensor. The data wire has a pull-up resistor. Either side may pull it low or let it float high. A start pulse launches one transfer. The block can first send a connection reset, and it always sends the start marker. It then shifts out an 8-bit command and reads the sensor's acknowledge bit. When it finishes, it reports completion and whether the acknowledge was missing.

All link timing comes from one phase length, counted in system clock cycles. Each clock high phase and each clock low phase lasts that long. The nominal phase is 125 µs, which is 31250 cycles at 250 MHz. Before the acknowledge pulse, the block releases the data wire. It then waits a separate, shorter settle time before raising the clock. The data input passes through a two-flop synchronizer, so the acknowledge is read from a metastability-safe copy. The reset input is asserted asynchronously and released on a clock edge.

Top module: `twowire_cmd_tx`

## Requirements
- R1: After reset the clock output is low, the data pull output is 0 (released), and busy, done and ack_error are all 0.
- R2: When the reset-enable input is 1 at the start request, the block sends nine clock pulses before the start marker and keeps the data pull at 0 throughout them. When it is 0, it sends no such pulses.
- R3: The start marker, beginning with the clock low and data released, is: clock up, data pulled low, clock down, clock up, data released, clock down. Each step lasts one phase.
- R4: The command is sent most significant bit first, one bit per clock pulse. A bit value of 0 means the data pull is 1 for that bit. Each command-bit clock pulse has a high phase and a low phase of TICK_CYC cycles each.
- R5: The data pull never changes in the same cycle as a clock edge. Outside the start marker, it never changes while the clock stays high.
- R6: After the eighth bit, the data pull is 0 for at least SETTLE_CYC cycles, with the clock low, before the ninth clock rises.
- R7: The acknowledge is taken from the synchronized data input during the ninth clock high phase. Low gives ack_error 0; high gives ack_error 1.
- R8: After the ninth clock falls, done is 1 for exactly one cycle, with the clock low and the data pull at 0. Busy is 0 in the following cycle.
- R9: A start request while busy is 1, including in the done cycle, is ignored. It does not change the command being sent and does not launch a new transfer.
- R10: ack_error keeps its value from the end of a transfer until the next accepted start request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer request, sampled when idle |
| cmd_i | input | CMD_W | Command byte, captured with the request |
| rst_en_i | input | 1 | Send the nine-pulse connection reset first |
| link_sck_o | output | 1 | Link clock, push-pull |
| link_pull_o | output | 1 | 1 pulls the data wire low, 0 releases it |
| link_dat_i | input | 1 | Level seen on the data wire |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_error_o | output | 1 | 1 when the sensor did not acknowledge |

## Verification
Two events can land in the same cycle: a new start request and the completion cycle of the transfer in progress. The bench provokes this by raising the request in exactly the cycle where done is seen, with a different command. It then judges that busy stays 0 and the link clock stays idle for a stretch afterwards. A second pair is a clock edge and a data-pull change. These meet at every bit boundary and when the data wire is released before the acknowledge. A monitor flags any cycle in which both outputs move together.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_HI,
    S_RST_LO,
    S_PRE,
    S_CK_UP1,
    S_DAT_DN,
    S_CK_DN1,
    S_CK_UP2,
    S_DAT_UP,
    S_CK_DN2,
    S_BIT_LO,
    S_BIT_HI,
    S_ACK_SET,
    S_ACK_HI,
    S_FIN
  } phase_e;
endpackage

// File: rtl/twc_sync2.sv
module twc_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_one
      assign ff_d = d_i;
    end else begin : g_chain
      assign ff_d = {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/twc_phase_timer.sv
module twc_phase_timer #(
  parameter int MAX_LEN = 31250,
  parameter int CW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = len_i - 1'b1;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == '0);

  // R4: a phase never lasts longer than the longest programmed length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAX_LEN));
endmodule

// File: rtl/twc_sequencer.sv
module twc_sequencer
  import twc_pkg::*;
#(
  parameter int TICK_CYC   = 31250,
  parameter int SETTLE_CYC = 500,
  parameter int CMD_W      = 8,
  parameter int RST_PULSES = 9,
  parameter int CW         = $clog2(TICK_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             rst_en_i,
  input  logic             dat_sync_i,
  input  logic             expire_i,
  output logic             load_o,
  output logic [CW-1:0]    len_o,
  output logic             sck_o,
  output logic             pull_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ack_err_o
);
  localparam int NMAX  = (RST_PULSES > CMD_W) ? RST_PULSES : CMD_W;
  localparam int NW    = $clog2(NMAX + 1);
  localparam logic [NW-1:0] RST_LAST = NW'(RST_PULSES - 1);
  localparam logic [NW-1:0] BIT_LAST = NW'(CMD_W - 1);
  localparam logic [CW-1:0] LEN_TICK = CW'(TICK_CYC);
  localparam logic [CW-1:0] LEN_SET  = CW'(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LEN_ONE  = CW'(1);

  phase_e           st_q, st_d;
  logic [CMD_W-1:0] sh_q, sh_d;
  logic [NW-1:0]    cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             sck_q, sck_d;
  logic             pull_q, pull_d;
  logic             sck_base, pull_base;

  // next-state process
  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    err_d = err_q;
    case (st_q)
      S_IDLE: if (start_i) begin
        sh_d  = cmd_i;
        cnt_d = '0;
        err_d = 1'b0;
        st_d  = rst_en_i ? S_RST_HI : S_PRE;
      end
      S_RST_HI: if (expire_i) st_d = S_RST_LO;
      S_RST_LO: if (expire_i) begin
        if (cnt_q == RST_LAST) begin
          cnt_d = '0;
          st_d  = S_PRE;
        end else begin
          cnt_d = cnt_q + 1'b1;
          st_d  = S_RST_HI;
        end
      end
      S_PRE:    if (expire_i) st_d = S_CK_UP1;
      S_CK_UP1: if (expire_i) st_d = S_DAT_DN;
      S_DAT_DN: if (expire_i) st_d = S_CK_DN1;
      S_CK_DN1: if (expire_i) st_d = S_CK_UP2;
      S_CK_UP2: if (expire_i) st_d = S_DAT_UP;
      S_DAT_UP: if (expire_i) st_d = S_CK_DN2;
      S_CK_DN2: if (expire_i) st_d = S_BIT_LO;
      S_BIT_LO: if (expire_i) st_d = S_BIT_HI;
      S_BIT_HI: if (expire_i) begin
        if (cnt_q == BIT_LAST) begin
          st_d = S_ACK_SET;
        end else begin
          cnt_d = cnt_q + 1'b1;
          sh_d  = {sh_q[CMD_W-2:0], 1'b0};
          st_d  = S_BIT_LO;
        end
      end
      S_ACK_SET: if (expire_i) st_d = S_ACK_HI;
      S_ACK_HI: if (expire_i) begin
        err_d = dat_sync_i;
        st_d  = S_FIN;
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase

    load_o = (st_d != st_q);
    if (st_d == S_ACK_SET)  len_o = LEN_SET;
    else if (st_d == S_FIN) len_o = LEN_ONE;
    else                    len_o = LEN_TICK;

    sck_base  = (st_d == S_RST_HI) || (st_d == S_CK_UP1) || (st_d == S_DAT_DN) ||
                (st_d == S_CK_UP2) || (st_d == S_DAT_UP) || (st_d == S_BIT_HI) ||
                (st_d == S_ACK_HI);
    pull_base = (st_d == S_DAT_DN) || (st_d == S_CK_DN1) || (st_d == S_CK_UP2) ||
                (((st_d == S_BIT_LO) || (st_d == S_BIT_HI)) && !sh_d[CMD_W-1]);
    sck_d  = sck_base;
    // keep data steady in the cycle the clock falls; change it one cycle later
    pull_d = (sck_q && !sck_base) ? pull_q : pull_base;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      sck_q  <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      sck_q  <= sck_d;
      pull_q <= pull_d;
    end
  end

  assign sck_o     = sck_q;
  assign pull_o    = pull_q;
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_FIN);
  assign ack_err_o = err_q;

  // R5: data pull is steady across every clock edge
  p_edge_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q != $past(sck_q)) |-> (pull_q == $past(pull_q)));
  // R5: with the clock held high, data moves only inside the start marker
  p_high_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q) && (pull_q != $past(pull_q))) |->
      ((st_q == S_DAT_DN) || (st_q == S_DAT_UP)));
  // R2: data released through the connection reset pulses
  p_rst_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_RST_HI) || (st_q == S_RST_LO)) |-> !pull_q);
  // R6: data released while the ninth clock is high
  p_ack_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ACK_HI) |-> !pull_q);
  // R7: ack flag follows the synchronized line at the end of the ninth high phase
  p_ack_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_ACK_HI) && expire_i) |=> (ack_err_o == $past(dat_sync_i)));
  // R8: done is a single cycle with the link idle, followed by idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!sck_q && !pull_q));
  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R9: captured command only shifts during the bit phases
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (st_q != S_BIT_HI)) |=> (sh_q == $past(sh_q)));
  // R10: ack flag only changes on completion or on an accepted start
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_err_o != $past(ack_err_o)) |-> (done_o || ($past(st_q) == S_IDLE)));
endmodule

// File: rtl/twowire_cmd_tx.sv
module twowire_cmd_tx #(
  parameter int TICK_CYC    = 31250,
  parameter int SETTLE_CYC  = 500,
  parameter int CMD_W       = 8,
  parameter int RST_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             rst_en_i,
  output logic             link_sck_o,
  output logic             link_pull_o,
  input  logic             link_dat_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ack_error_o
);
  localparam int CW = $clog2(TICK_CYC + 1);

  logic          rst_n_s;
  logic          dat_sync;
  logic          tmr_load;
  logic [CW-1:0] tmr_len;
  logic          tmr_expire;

  // asynchronous assert, synchronous release
  twc_sync2 #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_n_s)
  );

  twc_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dat_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (link_dat_i),
    .q_o   (dat_sync)
  );

  twc_phase_timer #(.MAX_LEN(TICK_CYC), .CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_expire)
  );

  twc_sequencer #(
    .TICK_CYC   (TICK_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .CMD_W      (CMD_W),
    .RST_PULSES (RST_PULSES),
    .CW         (CW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .cmd_i      (cmd_i),
    .rst_en_i   (rst_en_i),
    .dat_sync_i (dat_sync),
    .expire_i   (tmr_expire),
    .load_o     (tmr_load),
    .len_o      (tmr_len),
    .sck_o      (link_sck_o),
    .pull_o     (link_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ack_err_o  (ack_error_o)
  );
endmodule

// File: tb/tb_twowire_cmd_tx.sv
`timescale 1ns/1ps
module tb_twowire_cmd_tx;
  localparam int TICK   = 8;
  localparam int SETTLE = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] cmd_i = '0;
  logic       rst_en_i = 1'b0;
  logic       sck, pull, busy, done, ack_err;
  logic       sens_pull = 1'b0;
  logic       line;

  assign line = !(pull || sens_pull);

  twowire_cmd_tx #(.TICK_CYC(TICK), .SETTLE_CYC(SETTLE)) dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .cmd_i (cmd_i),
    .rst_en_i (rst_en_i), .link_sck_o (sck), .link_pull_o (pull),
    .link_dat_i (line), .busy_o (busy), .done_o (done), .ack_error_o (ack_err)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // link monitor and sensor model
  bit ack_en = 1'b0;
  bit p_sck = 1'b0, p_pull = 1'b0, p_line = 1'b1;
  bit fall_seen, started;
  int pre_rises, pre_pull_bad, rises, viol, hi_bad, lo_bad;
  int hi_cnt, lo_cnt, rel_cnt, settle_seen, done_cnt, done_bad;
  logic [7:0] byte_cap;
  bit rise_w, fall_w;

  always @(negedge clk) begin
    if (rst_n) begin
      rise_w = sck && !p_sck;
      fall_w = !sck && p_sck;
      if ((sck != p_sck) && (pull != p_pull)) viol++;
      if (sck && p_sck && (pull != p_pull) && started) viol++;
      if (!started) begin
        if (rise_w) pre_rises++;
        if (!fall_seen && sck && p_sck && p_line && !line) fall_seen = 1'b1;
        else if (fall_seen && sck && p_sck && !p_line && line) started = 1'b1;
        if (!fall_seen && pull) pre_pull_bad++;
      end else begin
        if (rise_w) begin
          if (rises >= 1 && rises <= 7 && lo_cnt != TICK) lo_bad++;
          rises++;
          if (rises <= 8) byte_cap = {byte_cap[6:0], line};
          else if (rises == 9) settle_seen = rel_cnt;
        end
        if (fall_w) begin
          if (rises >= 1 && hi_cnt != TICK) hi_bad++;
          if (rises == 8 && ack_en) sens_pull = 1'b1;
          if (rises == 9) sens_pull = 1'b0;
        end
      end
      if (sck)  hi_cnt = rise_w ? 1 : hi_cnt + 1;
      if (!sck) lo_cnt = fall_w ? 1 : lo_cnt + 1;
      rel_cnt = (!sck && !pull) ? rel_cnt + 1 : 0;
      if (done) begin
        done_cnt++;
        if (sck || pull) done_bad++;
      end
      p_sck = sck; p_pull = pull; p_line = line;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(negedge clk); #1;
    fall_seen = 0; started = 0; pre_rises = 0; pre_pull_bad = 0; rises = 0;
    viol = 0; hi_bad = 0; lo_bad = 0; settle_seen = 0; done_cnt = 0;
    done_bad = 0; byte_cap = '0; sens_pull = 0;
  endtask

  // poke: 0 none, 1 start request mid-transfer, 2 start request in the done cycle
  task automatic run_cmd(input logic [7:0] cmd, input bit rst_en, input bit ack,
                         input int poke, input string name);
    int guard;
    bit seen;
    mon_clear();
    ack_en = ack;
    @(negedge clk);
    cmd_i = cmd; rst_en_i = rst_en; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; cmd_i = ~cmd; rst_en_i = !rst_en;
    guard = 0; seen = 0;
    while (!seen && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (poke == 1 && guard == 60) start_i = 1'b1;
      if (poke == 1 && guard == 61) start_i = 1'b0;
      if (done) begin
        seen = 1;
        if (poke == 2) start_i = 1'b1;
      end
    end
    chk(seen, {name, " R8 done seen"}, seen, 1);
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy, {name, " R8 busy low after done"}, busy, 0);
    chk(pre_rises == (rst_en ? 11 : 2), {name, " R2 pulses before marker"}, pre_rises,
        rst_en ? 11 : 2);
    chk(pre_pull_bad == 0, {name, " R2 data released in reset"}, pre_pull_bad, 0);
    chk(started, {name, " R3 start marker"}, started, 1);
    chk(byte_cap == cmd, {name, " R4 command bits"}, byte_cap, cmd);
    chk(hi_bad == 0 && lo_bad == 0, {name, " R4 phase length"}, hi_bad + lo_bad, 0);
    chk(viol == 0, {name, " R5 data steady at edges"}, viol, 0);
    chk(settle_seen >= SETTLE, {name, " R6 settle"}, settle_seen, SETTLE);
    chk(ack_err == !ack, {name, " R7 ack flag"}, ack_err, !ack);
    chk(done_cnt == 1 && done_bad == 0, {name, " R8 single idle done"}, done_cnt, 1);
    if (poke == 2) begin
      repeat (3 * TICK) begin
        @(negedge clk);
        if (busy || sck) done_bad++;
      end
      chk(done_bad == 0, {name, " R9 start in done cycle ignored"}, done_bad, 0);
    end
    repeat (20) @(negedge clk);
    chk(ack_err == !ack, {name, " R10 ack flag held"}, ack_err, !ack);
  endtask

  task automatic t_reset_state();
    chk(!sck, "R1 clock low", sck, 0);
    chk(!pull, "R1 data released", pull, 0);
    chk(!busy && !done && !ack_err, "R1 status clear", {busy, done, ack_err}, 0);
  endtask

  task automatic t_humidity_with_reset();  run_cmd(8'h05, 1'b1, 1'b1, 0, "humid"); endtask
  task automatic t_temp_no_reset();        run_cmd(8'h03, 1'b0, 1'b1, 0, "temp");  endtask
  task automatic t_status_no_ack();        run_cmd(8'h07, 1'b0, 1'b0, 0, "nack");  endtask
  task automatic t_busy_request();         run_cmd(8'hA4, 1'b1, 1'b1, 1, "busy");  endtask
  task automatic t_done_collision();       run_cmd(8'h80, 1'b0, 1'b0, 2, "coll");  endtask
  task automatic t_ack_after_nack();       run_cmd(8'h5A, 1'b0, 1'b1, 0, "clr");   endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_humidity_with_reset();
    t_temp_no_reset();
    t_status_no_ack();
    t_busy_request();
    t_done_collision();
    t_ack_after_nack();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule